// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial shifter with a fixed bit rate. It supplies the shift clock itself and moves one byte at a time over a single bidirectional data line. In transmit it drives the line; in receive it releases the line and samples it. Every bit period takes exactly twelve oscillator clocks. The shift clock is low for the first ten of those clocks and high for the last two.

A transmit transfer starts when a byte-load strobe arrives while the port is idle. A receive transfer starts when receive-enable is high while the port is idle. If both are present in the same idle cycle, the load strobe wins. Bits travel least significant first. After the eighth bit the port pulses a one-cycle completion flag and returns to idle. During a receive transfer the received byte is published in that same completion cycle.

Top module: `sync_shift_port`

## Requirements
- R1: While reset is held and right after it is released, the shift clock is high, the output enable is low, the completion flag is low and the received-byte output is 0.
- R2: During a transfer each bit period lasts 12 clocks. Within a bit period the shift clock is low for clocks 0 to 9 and high for clocks 10 and 11.
- R3: In transmit, the data line shows bit k from the first clock of bit period k until that period ends. This places the bit 10 clocks ahead of the shift-clock rise and holds it 2 clocks after the rise.
- R4: A transfer moves exactly 8 bits, least significant bit first. Bit k of the byte belongs to bit period k.
- R5: In receive, the output enable stays low for the whole transfer. The data line value is sampled only at the clock edge on which the shift clock rises (the edge that ends clock 9 of each period). The line may change right after that edge.
- R6: The completion flag is high for exactly one cycle, the cycle that follows the 96th clock of the transfer. From that cycle on the port is idle: shift clock high, output enable low.
- R7: A load strobe that arrives during an active transfer is ignored. It changes neither the bits being sent nor starts a later transfer.
- R8: While idle, a high receive-enable starts a receive transfer. When a load strobe and receive-enable are both present in the same idle cycle, a transmit transfer starts.
- R9: The received-byte output changes only in the completion cycle of a receive transfer. A transmit transfer leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Byte-load strobe; starts a transmit transfer when idle |
| tx_byte_i | input | 8 | Byte to transmit, taken with load_i |
| rx_en_i | input | 1 | Receive-enable; starts a receive transfer when idle |
| rx_byte_o | output | 8 | Last byte received |
| done_o | output | 1 | One-cycle transfer completion flag |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_i | input | 1 | Data line input |
| sd_o | output | 1 | Data line output value |
| sd_oe_o | output | 1 | Data line output enable |

## Verification
During a receive, the bench drives the true bit only in the single cycle before the sampling edge and the inverted bit in every other cycle. A design that samples one clock early or late, or on the falling edge, therefore collects the complemented byte. Each transmit cycle is compared against the 10-low/2-high pattern and against the bit that should be on the line. A port that shifts one clock early, or sends the most significant bit first, shows a wrong bit inside the hold window. A load strobe is injected in the middle of a transmit transfer, and the bench then watches a long idle stretch. A port that reloaded would corrupt the remaining bits; one that queued the strobe would start a second transfer. Load and receive-enable are also raised together, and a receive is followed by a transmit. A port with inverted priority, or one that republishes its shift register after a transmit, changes the received-byte output.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

   // Transfer mode of the port
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_TX   = 2'd1,
      MODE_RX   = 2'd2
   } ssp_mode_e;

endpackage

// File: rtl/ssp_bit_timer.sv
`timescale 1ns/1ps
// Bit-period timer: counts oscillator clocks inside one bit period and
// derives the shift clock plus the rise and end-of-period strobes.
module ssp_bit_timer #(
   parameter int PERIOD_CLKS = 12,
   parameter int LOW_CLKS    = 10
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic end_o
);
   localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_CLKS - 1);
   localparam logic [CW-1:0] RISE_CNT = CW'(LOW_CLKS - 1);
   localparam logic [CW-1:0] HIGH_CNT = CW'(LOW_CLKS);

   initial begin
      assert (LOW_CLKS >= 1 && LOW_CLKS < PERIOD_CLKS)
         else $error("ssp_bit_timer: LOW_CLKS must lie in 1..PERIOD_CLKS-1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST_CNT) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign sclk_o = !run_i || (cnt_q >= HIGH_CNT);
   assign rise_o = run_i && (cnt_q == RISE_CNT);
   assign end_o  = run_i && (cnt_q == LAST_CNT);

   AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
      32'(cnt_q) < PERIOD_CLKS); // R2
   AST_RISE_GIVES_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> sclk_o); // R2
   AST_END_IN_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
      end_o |-> sclk_o); // R2

endmodule

// File: rtl/ssp_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: picks the mode, counts bits and raises completion.
module ssp_seq
   import ssp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      load_i,
   input  logic      rx_en_i,
   input  logic      bit_end_i,
   output ssp_mode_e mode_o,
   output logic      run_o,
   output logic      start_tx_o,
   output logic      fin_rx_o,
   output logic      done_o
);
   localparam int BW = $clog2(DATA_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   initial begin
      assert (DATA_W >= 2)
         else $error("ssp_seq: DATA_W must be at least 2");
   end

   ssp_mode_e     mode_q;
   logic [BW-1:0] bit_q;
   logic          done_q;
   logic          fin;

   assign fin        = (mode_q != MODE_IDLE) && bit_end_i && (bit_q == LAST_BIT);
   assign start_tx_o = (mode_q == MODE_IDLE) && load_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q <= MODE_IDLE;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         unique case (mode_q)
            MODE_IDLE: begin
               bit_q <= '0;
               if (load_i) begin
                  mode_q <= MODE_TX;
               end else if (rx_en_i) begin
                  mode_q <= MODE_RX;
               end
            end
            default: begin
               if (bit_end_i) begin
                  if (bit_q == LAST_BIT) begin
                     mode_q <= MODE_IDLE;
                     bit_q  <= '0;
                  end else begin
                     bit_q <= bit_q + BW'(1);
                  end
               end
            end
         endcase
      end
   end

   assign mode_o   = mode_q;
   assign run_o    = (mode_q != MODE_IDLE);
   assign fin_rx_o = fin && (mode_q == MODE_RX);
   assign done_o   = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |=> !done_q); // R6
   AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q != MODE_IDLE && !fin) |=> (mode_q == $past(mode_q))); // R7
   AST_BIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      32'(bit_q) < DATA_W); // R4
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |-> (mode_q == MODE_IDLE)); // R6

endmodule

// File: rtl/ssp_shreg.sv
`timescale 1ns/1ps
// Shift register shared by transmit and receive; bit order is a parameter.
module ssp_shreg #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              tx_shift_i,
   input  logic              rx_sample_i,
   input  logic              sd_i,
   output logic              ser_o,
   output logic [DATA_W-1:0] par_o
);
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] tx_next;
   logic [DATA_W-1:0] rx_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign tx_next = {1'b1, sh_q[DATA_W-1:1]};
         assign rx_next = {sd_i, sh_q[DATA_W-1:1]};
         assign ser_o   = sh_q[0];
      end else begin : g_msb
         assign tx_next = {sh_q[DATA_W-2:0], 1'b1};
         assign rx_next = {sh_q[DATA_W-2:0], sd_i};
         assign ser_o   = sh_q[DATA_W-1];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= load_data_i;
      end else if (tx_shift_i) begin
         sh_q <= tx_next;
      end else if (rx_sample_i) begin
         sh_q <= rx_next;
      end
   end

   assign par_o = sh_q;

   AST_SHREG_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      !(load_i || tx_shift_i || rx_sample_i) |=> $stable(par_o)); // R3

endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
// Half-duplex synchronous shift-register serial port, fixed bit rate.
module sync_shift_port
   import ssp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PERIOD_CLKS = 12,
   parameter int LOW_CLKS    = 10,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              rx_en_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              done_o,
   output logic              sclk_o,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe_o
);
   ssp_mode_e         mode;
   logic              run;
   logic              start_tx;
   logic              fin_rx;
   logic              bit_rise;
   logic              bit_end;
   logic              tx_shift;
   logic              rx_sample;
   logic              ser;
   logic [DATA_W-1:0] par;
   logic [DATA_W-1:0] rx_byte_q;

   ssp_seq #(
      .DATA_W (DATA_W)
   ) seq_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load_i),
      .rx_en_i    (rx_en_i),
      .bit_end_i  (bit_end),
      .mode_o     (mode),
      .run_o      (run),
      .start_tx_o (start_tx),
      .fin_rx_o   (fin_rx),
      .done_o     (done_o)
   );

   ssp_bit_timer #(
      .PERIOD_CLKS (PERIOD_CLKS),
      .LOW_CLKS    (LOW_CLKS)
   ) timer_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  (run),
      .sclk_o (sclk_o),
      .rise_o (bit_rise),
      .end_o  (bit_end)
   );

   assign tx_shift  = bit_end && (mode == MODE_TX);
   assign rx_sample = bit_rise && (mode == MODE_RX);

   ssp_shreg #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST)
   ) shreg_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .load_i      (start_tx),
      .load_data_i (tx_byte_i),
      .tx_shift_i  (tx_shift),
      .rx_sample_i (rx_sample),
      .sd_i        (sd_i),
      .ser_o       (ser),
      .par_o       (par)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rx_byte_q <= '0;
      end else if (fin_rx) begin
         rx_byte_q <= par;
      end
   end

   assign rx_byte_o = rx_byte_q;
   assign sd_oe_o   = (mode == MODE_TX);
   assign sd_o      = (mode == MODE_TX) ? ser : 1'b1;

   AST_IDLE_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode == MODE_IDLE) |-> sclk_o); // R6
   AST_TX_BIT_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (sd_oe_o && $past(sd_oe_o) && !$past(tx_shift)) |-> $stable(sd_o)); // R3
   AST_RX_LINE_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode == MODE_RX) |-> !sd_oe_o); // R5
   AST_RXBYTE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(fin_rx) |-> $stable(rx_byte_o)); // R9
   AST_DONE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> $past(run)); // R6

endmodule

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       load;
   logic [7:0] tx_byte;
   logic       rx_en;
   logic [7:0] rx_byte;
   logic       done;
   logic       sclk;
   logic       sd_in;
   logic       sd_out;
   logic       sd_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sync_shift_port dut_i (
      .clk_i     (clk),
      .rst_i     (rst),
      .load_i    (load),
      .tx_byte_i (tx_byte),
      .rx_en_i   (rx_en),
      .rx_byte_o (rx_byte),
      .done_o    (done),
      .sclk_o    (sclk),
      .sd_i      (sd_in),
      .sd_o      (sd_out),
      .sd_oe_o   (sd_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Runs one transfer and checks every cycle of it.
   // tx_mode: load strobe (with rx_en also high when both=1), else rx_en.
   task automatic run_xfer(input bit tx_mode, input logic [7:0] txb,
                           input logic [7:0] rxb, input bit inject_load,
                           input bit both, input logic [7:0] exp_rx);
      @(negedge clk);
      sd_in = 1'b1;
      if (tx_mode) begin
         load    = 1'b1;
         tx_byte = txb;
         rx_en   = both;
      end else begin
         rx_en = 1'b1;
      end
      @(posedge clk);
      for (int j = 0; j < 96; j++) begin
         int k;
         int ph;
         @(negedge clk);
         k  = j / 12;
         ph = j % 12;
         load  = (inject_load && j == 30);
         rx_en = 1'b0;
         if (inject_load && j == 30) tx_byte = ~txb;
         chk(sclk == (ph >= 10), "R2 shift clock phase", sclk, ph >= 10);
         chk(done == 1'b0, "R6 done early", done, 0);
         if (tx_mode) begin
            chk(sd_oe == 1'b1, "R8 transmit selected", sd_oe, 1);
            chk(sd_out == txb[k], "R3 R4 transmit bit", sd_out, txb[k]);
         end else begin
            chk(sd_oe == 1'b0, "R5 line released", sd_oe, 0);
            sd_in = (ph == 9) ? rxb[k] : ~rxb[k];
         end
      end
      @(negedge clk);
      load  = 1'b0;
      sd_in = 1'b1;
      chk(done == 1'b1, "R6 done pulse", done, 1);
      chk(sclk == 1'b1, "R6 idle clock", sclk, 1);
      chk(sd_oe == 1'b0, "R6 idle release", sd_oe, 0);
      chk(rx_byte == exp_rx, "R5 R9 received byte", rx_byte, exp_rx);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(done == 1'b0, "R6 done one cycle", done, 0);
         chk(sclk == 1'b1 && sd_oe == 1'b0, "R7 stays idle", {sclk, sd_oe}, 2);
      end
      chk(rx_byte == exp_rx, "R9 received byte hold", rx_byte, exp_rx);
   endtask

   task automatic t_reset();
      rst = 1'b1; load = 1'b0; tx_byte = 8'h00; rx_en = 1'b0; sd_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(sclk == 1'b1, "R1 reset clock", sclk, 1);
      chk(sd_oe == 1'b0, "R1 reset enable", sd_oe, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R1 reset done", done, 0);
      chk(rx_byte == 8'h00, "R1 reset byte", rx_byte, 0);
      chk(sclk == 1'b1 && sd_oe == 1'b0, "R1 idle after reset", {sclk, sd_oe}, 2);
   endtask

   task automatic t_tx_basic();      // R2 R3 R4 R6
      run_xfer(1'b1, 8'hA5, 8'h00, 1'b0, 1'b0, 8'h00);
      run_xfer(1'b1, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_rx_basic();      // R5 R8
      run_xfer(1'b0, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h5A);
      run_xfer(1'b0, 8'h00, 8'h81, 1'b0, 1'b0, 8'h81);
   endtask

   task automatic t_load_busy();     // R7
      run_xfer(1'b1, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h81);
   endtask

   task automatic t_priority();      // R8 R9
      run_xfer(1'b1, 8'hF0, 8'h00, 1'b0, 1'b1, 8'h81);
   endtask

   task automatic t_rx_then_tx();    // R9
      run_xfer(1'b0, 8'h00, 8'hC7, 1'b0, 1'b0, 8'hC7);
      run_xfer(1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 8'hC7);
   endtask

   initial begin
      t_reset();
      t_tx_basic();
      t_rx_basic();
      t_load_busy();
      t_priority();
      t_rx_then_tx();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule